// File: doc/BRIEF.md
# HDB3/AMI Line Decoder

This block turns two unipolar rails back into NRZ data. The rails come from an external line receiver that has already split a ternary bipolar signal into a positive-mark rail and a negative-mark rail, and the block samples them on the rising edge of a recovered receive clock. In HDB3 mode it finds the substitution violations and decodes the four-bit substitution groups back to zeros. In AMI mode it decodes every mark as a one. In both modes it flags bits that break the coding rule on an error output, and it keeps that output aligned with the data bit it refers to.

The block also drives a clock-indication output, which is the plain OR of the rails currently selected. Clock-extraction logic outside the block can use it. When loop-test is enabled, the rails of the local encoder are used instead of the external receiver rails, both for decoding and for the clock indication. This closes a loop from transmit to receive inside the chip.

Top module: `hdb3_rx_decoder`

## Requirements
- R1: With loop_en_i low, clk_ind_o equals rx_pos_i OR rx_neg_i combinationally, with no clock delay.
- R2: With loop_en_i high, lb_pos_i and lb_neg_i replace rx_pos_i and rx_neg_i both for decoding and for clk_ind_o. The external rails then have no effect.
- R3: A rail pair sampled at rising edge k shows its decoded bit on nrz_o and its error flag on err_o from rising edge k+3 until edge k+4. This is four edges counting the sampling edge.
- R4: With hdb3_mode_i = 0 (AMI), a single mark decodes as 1 and a space decodes as 0. A mark with the same polarity as the previous mark raises err_o for that bit and still decodes as 1. No bit is ever replaced.
- R5: With hdb3_mode_i = 1 (HDB3), a mark with the same polarity as the previous mark is a violation. The violation is valid if it is the first violation since reset or if its polarity is opposite to the previous violation. A valid violation decodes as 0. The bit sampled three edges before it also decodes as 0, unless that bit was flagged as an error. A valid violation does not raise err_o.
- R6: In HDB3 mode, a violation with the same polarity as the previous violation raises err_o for that bit, decodes as 1, and clears no earlier bit.
- R7: Both rails high in the same period raises err_o for that bit and decodes as 1. It does not change the stored mark or violation polarity history.
- R8: While rst_ni is low, nrz_o and err_o are 0. After reset the polarity history is empty, so the first mark is never a violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Recovered receive clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hdb3_mode_i | input | 1 | 1 = HDB3 decoding, 0 = AMI decoding |
| loop_en_i | input | 1 | 1 = decode the local encoder rails |
| rx_pos_i | input | 1 | External positive-mark rail |
| rx_neg_i | input | 1 | External negative-mark rail |
| lb_pos_i | input | 1 | Local encoder positive-mark rail |
| lb_neg_i | input | 1 | Local encoder negative-mark rail |
| nrz_o | output | 1 | Decoded NRZ data |
| err_o | output | 1 | Coding-rule error, aligned with nrz_o |
| clk_ind_o | output | 1 | OR of the selected rails |

## Verification
Wrong polarity or violation history is visible at the ports at the next mark that depends on it. A valid violation would then come out as a 1 with err_o set, or a bad one would come out as a 0, exactly three edges after that mark is sampled. A clear applied to the wrong pipeline stage shows a leading substitution mark as a stray 1, or wipes a real data bit, in the same latency window. A latency or alignment fault shifts every decoded bit, so the first directed sequence after reset exposes it.

// File: rtl/hdb3_dec_pkg.sv
package hdb3_dec_pkg;
  typedef enum logic {
    CODE_AMI  = 1'b0,
    CODE_HDB3 = 1'b1
  } code_mode_e;

  // one decoded position travelling through the alignment pipe
  typedef struct packed {
    logic one;
    logic err;
  } dec_bit_t;

  // distance from a substitution violation back to its leading mark
  localparam int unsigned SUB_GAP = 3;
endpackage

// File: rtl/hdb3_rail_select.sv
module hdb3_rail_select (
  input  logic loop_en_i,
  input  logic rx_pos_i,
  input  logic rx_neg_i,
  input  logic lb_pos_i,
  input  logic lb_neg_i,
  output logic pos_o,
  output logic neg_o,
  output logic clk_ind_o
);
  always_comb begin
    pos_o     = loop_en_i ? lb_pos_i : rx_pos_i;
    neg_o     = loop_en_i ? lb_neg_i : rx_neg_i;
    clk_ind_o = pos_o | neg_o;
  end
endmodule

// File: rtl/hdb3_viol_classifier.sv
module hdb3_viol_classifier
  import hdb3_dec_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     hdb3_i,
  input  logic     pos_i,
  input  logic     neg_i,
  output dec_bit_t bit_o,
  output logic     clr_o
);
  logic mark_seen_q, last_pos_q;
  logic viol_seen_q, last_viol_pos_q;
  logic both, single, same_pol, valid_v, bad_v;

  always_comb begin
    both     = pos_i & neg_i;
    single   = pos_i ^ neg_i;
    same_pol = single & mark_seen_q & (pos_i == last_pos_q);
    valid_v  = 1'b0;
    bad_v    = 1'b0;
    if (code_mode_e'(hdb3_i) == CODE_HDB3) begin
      valid_v = same_pol & (~viol_seen_q | (pos_i != last_viol_pos_q));
      bad_v   = same_pol & ~valid_v;
    end else begin
      bad_v   = same_pol;
    end
    bit_o.one = (pos_i | neg_i) & ~valid_v;
    bit_o.err = both | bad_v;
    clr_o     = valid_v;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mark_seen_q     <= 1'b0;
      last_pos_q      <= 1'b0;
      viol_seen_q     <= 1'b0;
      last_viol_pos_q <= 1'b0;
    end else begin
      if (single) begin
        mark_seen_q <= 1'b1;
        last_pos_q  <= pos_i;
      end
      if (hdb3_i && same_pol) begin
        viol_seen_q     <= 1'b1;
        last_viol_pos_q <= pos_i;
      end
    end
  end

  // R4: AMI never replaces bits
  assert_ami_no_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hdb3_i |-> !clr_o);
  // R7: simultaneous marks leave polarity history untouched
  assert_both_keeps_history_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pos_i && neg_i) |=> ($stable(last_pos_q) && $stable(last_viol_pos_q)));
endmodule

// File: rtl/hdb3_align_pipe.sv
module hdb3_align_pipe
  import hdb3_dec_pkg::*;
#(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned GAP   = SUB_GAP
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  dec_bit_t bit_i,
  input  logic     clr_i,
  output dec_bit_t bit_o
);
  dec_bit_t stg_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= bit_i;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    if (g == GAP) begin : g_sub
      // leading mark of a substitution group is cleared unless it was an error
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else begin
          stg_q[g].err <= stg_q[g-1].err;
          stg_q[g].one <= stg_q[g-1].one & ~(clr_i & ~stg_q[g-1].err);
        end
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[g] <= '0;
        else         stg_q[g] <= stg_q[g-1];
      end
    end
  end

  assign bit_o = stg_q[DEPTH-1];

  // R5: a valid violation removes the leading mark three positions back
  assert_sub_clears_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !stg_q[GAP-1].err) |=> !stg_q[GAP].one);
endmodule

// File: rtl/hdb3_rx_decoder.sv
module hdb3_rx_decoder
  import hdb3_dec_pkg::*;
#(
  parameter int unsigned LATENCY = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hdb3_mode_i,
  input  logic loop_en_i,
  input  logic rx_pos_i,
  input  logic rx_neg_i,
  input  logic lb_pos_i,
  input  logic lb_neg_i,
  output logic nrz_o,
  output logic err_o,
  output logic clk_ind_o
);
  localparam int unsigned PIPE_DEPTH = (LATENCY > SUB_GAP) ? LATENCY : SUB_GAP + 1;

  logic     sel_pos, sel_neg, clr;
  dec_bit_t cls_bit, out_bit;

  hdb3_rail_select u_sel (
    .loop_en_i (loop_en_i),
    .rx_pos_i  (rx_pos_i),
    .rx_neg_i  (rx_neg_i),
    .lb_pos_i  (lb_pos_i),
    .lb_neg_i  (lb_neg_i),
    .pos_o     (sel_pos),
    .neg_o     (sel_neg),
    .clk_ind_o (clk_ind_o)
  );

  hdb3_viol_classifier u_cls (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hdb3_i (hdb3_mode_i),
    .pos_i  (sel_pos),
    .neg_i  (sel_neg),
    .bit_o  (cls_bit),
    .clr_o  (clr)
  );

  hdb3_align_pipe #(.DEPTH(PIPE_DEPTH), .GAP(SUB_GAP)) u_pipe (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bit_i  (cls_bit),
    .clr_i  (clr),
    .bit_o  (out_bit)
  );

  assign nrz_o = out_bit.one;
  assign err_o = out_bit.err;

  // R6 and R7: every flagged bit decodes as one
  assert_err_is_one_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> nrz_o);
  assert_loop_clk_ind_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    loop_en_i |-> (clk_ind_o == (lb_pos_i | lb_neg_i)));
  assert_ext_clk_ind_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loop_en_i |-> (clk_ind_o == (rx_pos_i | rx_neg_i)));
  assert_reset_quiet_R8: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (!nrz_o && !err_o));
endmodule

// File: tb/hdb3_rx_decoder_bench.sv
`timescale 1ns/1ps
module hdb3_rx_decoder_bench;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic hdb3_mode = 1'b0, loop_en = 1'b0;
  logic rx_pos = 1'b0, rx_neg = 1'b0, lb_pos = 1'b0, lb_neg = 1'b0;
  logic nrz, err, clk_ind;
  int total = 0, fails = 0;

  always #2 clk = ~clk;

  hdb3_rx_decoder u_hdb3_rx_decoder (
    .clk_i(clk), .rst_ni(rst_ni), .hdb3_mode_i(hdb3_mode), .loop_en_i(loop_en),
    .rx_pos_i(rx_pos), .rx_neg_i(rx_neg), .lb_pos_i(lb_pos), .lb_neg_i(lb_neg),
    .nrz_o(nrz), .err_o(err), .clk_ind_o(clk_ind)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; loop_en = 1'b0;
    rx_pos = 1'b0; rx_neg = 1'b0; lb_pos = 1'b0; lb_neg = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    chk("R8", "nrz in reset", nrz, 1'b0);
    chk("R8", "err in reset", err, 1'b0);
    rst_ni = 1'b1;
  endtask

  // bit i of p/m is the rail pair of step i; en/ee give decoded bit i
  task automatic run_seq(input string req, input logic mode, input logic lb, input int n,
                         input logic [15:0] p, input logic [15:0] m,
                         input logic [15:0] en, input logic [15:0] ee);
    do_reset();
    hdb3_mode = mode;
    loop_en = lb;
    for (int i = 0; i < n + 3; i++) begin
      logic sp, sm;
      sp = (i < n) ? p[i] : 1'b0;
      sm = (i < n) ? m[i] : 1'b0;
      if (lb) begin
        lb_pos = sp; lb_neg = sm;
        rx_pos = (i < n); rx_neg = (i < n);
      end else begin
        rx_pos = sp; rx_neg = sm;
      end
      #0.5;
      chk(lb ? "R2" : "R1", "clk_ind", clk_ind, sp | sm);
      @(posedge clk);
      #1;
      if (i < 3) begin
        chk("R3", "nrz before latency", nrz, 1'b0);
      end else begin
        chk(req, $sformatf("nrz bit %0d", i - 3), nrz, en[i-3]);
        chk(req, $sformatf("err bit %0d", i - 3), err, ee[i-3]);
      end
    end
    loop_en = 1'b0;
  endtask

  task automatic t_first_mark_R8();
    run_seq("R8", 1'b0, 1'b0, 1, 16'b0, 16'b1, 16'b1, 16'b0);
  endtask

  task automatic t_ami_R4();
    run_seq("R4", 1'b0, 1'b0, 5, 16'b11001, 16'b00100, 16'b11101, 16'b10000);
  endtask

  task automatic t_hdb3_sub_R5();
    run_seq("R5", 1'b1, 1'b0, 9, 16'b000010001, 16'b100100000, 16'b000000001, 16'b0);
  endtask

  task automatic t_bad_viol_R6();
    run_seq("R6", 1'b1, 1'b0, 10, 16'b1001010001, 16'b0000100000,
            16'b1001100001, 16'b1000000000);
  endtask

  task automatic t_both_rails_R7();
    run_seq("R7", 1'b1, 1'b0, 3, 16'b111, 16'b010, 16'b011, 16'b010);
  endtask

  task automatic t_loopback_R2();
    run_seq("R2", 1'b1, 1'b1, 4, 16'b0001, 16'b0100, 16'b0101, 16'b0);
  endtask

  initial begin
    #200000;
    fails++; total++;
    $display("FAIL watchdog: actual running expected done");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    t_first_mark_R8();
    t_ami_R4();
    t_hdb3_sub_R5();
    t_bad_viol_R6();
    t_both_rails_R7();
    t_loopback_R2();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule